// File: doc/BRIEF.md
# Seeded Inclusive Prefix-Sum Engine

This block forms a running total over the active elements of a packed vector of 32-bit words. A single start pulse hands it a length, a source vector, a scalar seed and an optional per-element mask. Result slot `i` then receives the seed plus every enabled source element from slot 0 up to and including slot `i`. The engine handles one element per clock. When it finishes, it raises a one-cycle done pulse and presents the closing total.

The closing total is meant to be fed back as the seed of the next call. A long array can then be cut into strips of up to `NUM_ELEM` words, and the strips still form one unbroken scan. The result vector is held inside the block between operations. Slots that are masked off, and slots past the active length, keep whatever an earlier operation left there.

Top module: `prefix_scan_unit`

## Requirements
- R1: After an operation with no mask, result slot i equals the seed plus the sum of source slots 0 to i, for every i below the active length (an inclusive scan).
- R2: All additions wrap modulo 2^32, and no overflow indication exists.
- R3: When `mask_en_i` is 1, a slot whose bit in `mask_i` (bit i for slot i) is 0 adds nothing to the running total and its result slot keeps its previous value. When `mask_en_i` is 0, every slot is enabled.
- R4: Result slots at or beyond the active length keep their previous values. A length above `NUM_ELEM` is treated as `NUM_ELEM`.
- R5: `total_o` equals the running total after the last active slot, or the seed when no slot is enabled. It is updated in the same cycle that `done_o` rises and holds otherwise.
- R6: A start with a nonzero length taken while idle makes `busy_o` high from the next cycle for exactly `len` cycles. `done_o` pulses for one cycle, together with the final results, `len` cycles after the start edge, and `busy_o` falls in that same cycle.
- R7: A start with length 0 does nothing: `busy_o` and `done_o` stay low, and the result and total are unchanged.
- R8: A start pulse that arrives while `busy_o` is high is ignored. The running operation completes with its own data and no second operation follows.
- R9: Reset (synchronous, active high) clears every result slot and `total_o` to 0, and drives `busy_o` and `done_o` low.
- R10: Feeding `total_o` back as the seed of the next operation continues the prefix sum across strips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; operands are captured on this edge |
| len_i | input | $clog2(NUM_ELEM+1) | Active element count |
| src_i | input | NUM_ELEM*ELEM_W | Packed source words, slot 0 in the low bits |
| seed_i | input | ELEM_W | Scalar seed of the scan |
| mask_i | input | NUM_ELEM | Per-slot enable, bit i for slot i |
| mask_en_i | input | 1 | 1 applies mask_i, 0 enables every slot |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dst_o | output | NUM_ELEM*ELEM_W | Held result vector, slot 0 in the low bits |
| total_o | output | ELEM_W | Closing running total for chaining |

## Verification
Operands are captured on the start edge. Each following edge processes one slot. The final slot's result, `total_o` and `done_o` all become visible after the `len`-th edge past the start edge. The bench drives inputs on falling edges. It then counts exactly `len` falling edges, checks that `done_o` stays low at every earlier edge, and requires it high at the last one. It compares the full result vector and the total only in that done cycle, then checks on the next falling edge that `busy_o` and `done_o` are low. For the zero-length case and for the start pulse given while busy, it watches the same counted window to confirm that no extra activity appears.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic {
    SC_IDLE = 1'b0,
    SC_RUN  = 1'b1
  } scan_state_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl #(
  parameter int NUM_ELEM = 8,
  parameter int LEN_W    = 4,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             load_o,
  output logic             step_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o
);
  import scan_pkg::*;

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(NUM_ELEM);

  scan_state_t      state_q;
  logic [LEN_W-1:0] len_q;
  logic [IDX_W-1:0] idx_q;
  logic [LEN_W-1:0] len_eff;

  // lengths above capacity are clamped
  assign len_eff = (len_i > MAX_LEN) ? MAX_LEN : len_i;
  assign load_o  = start_i && (state_q == SC_IDLE) && (len_i != '0);
  assign step_o  = (state_q == SC_RUN);
  assign last_o  = step_o && ((LEN_W'(idx_q) + LEN_W'(1)) == len_q);
  assign busy_o  = (state_q == SC_RUN);
  assign idx_o   = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SC_IDLE;
      len_q   <= '0;
      idx_q   <= '0;
    end else begin
      if (load_o) begin
        state_q <= SC_RUN;
        len_q   <= len_eff;
        idx_q   <= '0;
      end else if (step_o) begin
        if (last_o) begin
          state_q <= SC_IDLE;
          idx_q   <= '0;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/scan_accum.sv
module scan_accum #(
  parameter int ELEM_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ELEM_W-1:0] seed_i,
  input  logic              step_i,
  input  logic              add_en_i,
  input  logic [ELEM_W-1:0] elem_i,
  output logic [ELEM_W-1:0] sum_o
);
  logic [ELEM_W-1:0] acc_q;

  // wraps naturally modulo 2^ELEM_W
  assign sum_o = add_en_i ? (acc_q + elem_i) : acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (load_i) begin
      acc_q <= seed_i;
    end else if (step_i) begin
      acc_q <= sum_o;
    end
  end
endmodule

// File: rtl/scan_dest.sv
module scan_dest #(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 32,
  parameter int IDX_W    = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [ELEM_W-1:0]            data_i,
  output logic [NUM_ELEM*ELEM_W-1:0]   vec_o
);
  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_slot
    logic [ELEM_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q <= '0;
      end else if (we_i && (idx_i == IDX_W'(g))) begin
        slot_q <= data_i;
      end
    end
    assign vec_o[g*ELEM_W +: ELEM_W] = slot_q;
  end
endmodule

// File: rtl/prefix_scan_unit.sv
module prefix_scan_unit #(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 32,
  parameter int LEN_W    = $clog2(NUM_ELEM + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic [LEN_W-1:0]           len_i,
  input  logic [NUM_ELEM*ELEM_W-1:0] src_i,
  input  logic [ELEM_W-1:0]          seed_i,
  input  logic [NUM_ELEM-1:0]        mask_i,
  input  logic                       mask_en_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [NUM_ELEM*ELEM_W-1:0] dst_o,
  output logic [ELEM_W-1:0]          total_o
);
  localparam int IDX_W = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1;

  logic                       load, step, last;
  logic [IDX_W-1:0]           idx;
  logic [NUM_ELEM*ELEM_W-1:0] src_q;
  logic [NUM_ELEM-1:0]        en_q;
  logic [ELEM_W-1:0]          elem;
  logic                       add_en;
  logic [ELEM_W-1:0]          sum;
  logic                       done_q;
  logic [ELEM_W-1:0]          total_q;

  scan_ctrl #(.NUM_ELEM(NUM_ELEM), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i),
    .busy_o(busy_o), .load_o(load), .step_o(step), .last_o(last), .idx_o(idx)
  );

  // operand capture on the accepted start
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      en_q  <= '0;
    end else if (load) begin
      src_q <= src_i;
      en_q  <= mask_en_i ? mask_i : '1;
    end
  end

  assign elem   = src_q[idx*ELEM_W +: ELEM_W];
  assign add_en = en_q[idx];

  scan_accum #(.ELEM_W(ELEM_W)) u_acc (
    .clk(clk), .rst(rst), .load_i(load), .seed_i(seed_i),
    .step_i(step), .add_en_i(add_en), .elem_i(elem), .sum_o(sum)
  );

  scan_dest #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W), .IDX_W(IDX_W)) u_dst (
    .clk(clk), .rst(rst), .we_i(step && add_en), .idx_i(idx),
    .data_i(sum), .vec_o(dst_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      total_q <= '0;
    end else begin
      done_q <= last;
      if (last) total_q <= sum;
    end
  end

  assign done_o  = done_q;
  assign total_o = total_q;
endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 32,
  parameter int LEN_W    = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       start_i,
  input logic [LEN_W-1:0]           len_i,
  input logic                       busy_o,
  input logic                       done_o,
  input logic [NUM_ELEM*ELEM_W-1:0] dst_o,
  input logic [ELEM_W-1:0]          total_o
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(busy_o) && !busy_o));
  // R6
  start_runs_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && (len_i != '0)) |=> busy_o);
  // R7
  zero_len_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && (len_i == '0)) |=> (!busy_o && !done_o));
  // R4
  idle_dst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> $stable(dst_o));
  // R5
  total_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(total_o));
endmodule

bind prefix_scan_unit scan_checker #(
  .NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i),
  .busy_o(busy_o), .done_o(done_o), .dst_o(dst_o), .total_o(total_o)
);

// File: tb/sim_prefix_scan_unit.sv
module sim_prefix_scan_unit;
  localparam int N = 8;
  localparam int W = 32;
  localparam int LW = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start_i = 1'b0;
  logic [LW-1:0]  len_i = '0;
  logic [N*W-1:0] src_i = '0;
  logic [W-1:0]   seed_i = '0;
  logic [N-1:0]   mask_i = '0;
  logic           mask_en_i = 1'b0;
  logic           busy_o, done_o;
  logic [N*W-1:0] dst_o;
  logic [W-1:0]   total_o;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_dst [N];
  logic [W-1:0] exp_total;

  always #2 clk = ~clk;

  prefix_scan_unit #(.NUM_ELEM(N), .ELEM_W(W)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i), .src_i(src_i),
    .seed_i(seed_i), .mask_i(mask_i), .mask_en_i(mask_en_i),
    .busy_o(busy_o), .done_o(done_o), .dst_o(dst_o), .total_o(total_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    for (int i = 0; i < N; i++) check(req, dst_o[i*W +: W], exp_dst[i]);
    check(req, total_o, exp_total);
  endtask

  // one operation; poke=1 fires an extra start while busy (R8)
  task automatic run_op(input string req, input int len, input logic [N*W-1:0] src,
                        input logic [W-1:0] seed, input logic [N-1:0] mask,
                        input logic men, input bit poke);
    int eff;
    logic [W-1:0] sum;
    eff = (len > N) ? N : len;
    sum = seed;
    for (int i = 0; i < eff; i++) begin
      if (!men || mask[i]) begin
        sum = sum + src[i*W +: W];
        exp_dst[i] = sum;
      end
    end
    if (eff != 0) exp_total = sum;
    @(negedge clk);
    start_i = 1'b1; len_i = LW'(len); src_i = src; seed_i = seed;
    mask_i = mask; mask_en_i = men;
    @(negedge clk);
    start_i = 1'b0; src_i = ~src; seed_i = ~seed;
    if (eff == 0) begin
      for (int k = 0; k < 4; k++) begin
        check({req, " R7 busy"}, W'(busy_o), '0);
        check({req, " R7 done"}, W'(done_o), '0);
        @(negedge clk);
      end
      check_outputs({req, " R7 outputs"});
      return;
    end
    check({req, " R6 busy"}, W'(busy_o), 1);
    for (int k = 1; k <= eff; k++) begin
      if (k < eff) check({req, " R6 early done"}, W'(done_o), '0);
      if (poke && k == 1) begin start_i = 1'b1; len_i = 4'd2; seed_i = 32'h999; end
      if (poke && k == 2) start_i = 1'b0;
      @(negedge clk);
    end
    check({req, " R6 done"}, W'(done_o), 1);
    check({req, " R6 busy low"}, W'(busy_o), '0);
    check_outputs(req);
    @(negedge clk);
    check({req, " R6 done pulse"}, W'(done_o), '0);
    check({req, " R8 no rerun"}, W'(busy_o), '0);
  endtask

  function automatic logic [N*W-1:0] pack(input int base, input int stepv);
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(base + i * stepv);
    return v;
  endfunction

  task automatic t_reset();
    for (int i = 0; i < N; i++) exp_dst[i] = '0;
    exp_total = '0;
    check("R9 busy", W'(busy_o), '0);
    check("R9 done", W'(done_o), '0);
    check_outputs("R9 reset");
  endtask

  task automatic t_full();      run_op("R1 full", 8, pack(1, 1), 32'd100, '0, 1'b0, 0); endtask
  task automatic t_partial();   run_op("R4 partial", 3, pack(10, 5), 32'd0, 8'hFF, 1'b0, 0); endtask
  task automatic t_mask();      run_op("R3 mask", 8, pack(3, 2), 32'd7, 8'b1010_0110, 1'b1, 0); endtask
  task automatic t_allmask();   run_op("R5 all masked", 5, pack(9, 1), 32'h55, 8'h00, 1'b1, 0); endtask
  task automatic t_wrap();      run_op("R2 wrap", 4, pack(32'h7FFF_FFFF, 32'h4000_0000), 32'hFFFF_FFF0, '0, 1'b0, 0); endtask
  task automatic t_zero();      run_op("R7 zero", 0, pack(5, 5), 32'd1, '0, 1'b0, 0); endtask
  task automatic t_busy();      run_op("R8 busy start", 6, pack(2, 3), 32'd4, '0, 1'b0, 1); endtask
  task automatic t_clamp();     run_op("R4 clamp", 12, pack(1, 2), 32'd0, '0, 1'b0, 0); endtask

  task automatic t_chain();
    logic [W-1:0] carry;
    logic [W-1:0] ref_sum;
    run_op("R10 strip a", 8, pack(1, 1), 32'd0, '0, 1'b0, 0);
    carry = total_o;
    run_op("R10 strip b", 3, pack(9, 1), carry, '0, 1'b0, 0);
    ref_sum = '0;
    for (int i = 1; i <= 11; i++) ref_sum = ref_sum + W'(i);
    check("R10 continuous total", total_o, ref_sum);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full();
    t_partial();
    t_mask();
    t_allmask();
    t_wrap();
    t_zero();
    t_busy();
    t_clamp();
    t_chain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R6 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule